// File: doc/BRIEF.md
# Multiprocessor 9-bit UART receiver

This block is the receive half of a serial port that sits on a bus shared by one master and several slaves. A frame is a low start bit, then the data bits least significant first, then a high stop bit. In the 9-bit operating mode the data field is eight bits plus a ninth bit. The ninth bit tags the frame: 1 marks an address frame and 0 marks a data frame. In the 8-bit mode the data field is eight bits and the tag does not exist.

A filter-enable bit makes a slave deaf to data frames. While it is set in 9-bit mode, only address frames raise the receive interrupt and reach the holding registers. A hardware comparator checks every such address frame against a programmable own address and an optional broadcast address. On a hit it clears the filter-enable bit and marks the slave as addressed, so the data frames that follow are delivered. When the message is over, software re-arms the filter with a strobe and the slave goes back to waiting for the next address.

The line input is brought into the clock domain by a two-flop synchronizer and sampled in the middle of each bit. The sample point comes from an oversampling tick supplied from outside the block.

Top module: `mpUartRx`

## Requirements
- R1: After reset rxIrq, frameErr, mpEnable, addressed, rxNinth are 0 and rxData is 0x00.
- R2: Bits are received least significant first. In 9-bit mode (modeNine=1) the ninth received bit appears on rxNinth. In 8-bit mode (modeNine=0) eight bits are received and a delivered frame leaves rxNinth at 0.
- R3: In 9-bit mode with mpEnable=0, every frame with a high stop bit sets rxIrq and loads rxData/rxNinth, whatever its ninth bit.
- R4: In 9-bit mode with mpEnable=1, a frame whose ninth bit is 0 leaves rxIrq, rxData, rxNinth, mpEnable and addressed unchanged.
- R5: In 9-bit mode with mpEnable=1, a frame whose ninth bit is 1 is delivered. If its byte equals ownAddr, or equals bcastAddr while bcastEn=1, mpEnable becomes 0 and addressed becomes 1. Otherwise both are unchanged. The comparator does nothing while mpEnable=0.
- R6: A one-cycle pulse on mpArm sets mpEnable to 1 and clears addressed.
- R7: In 8-bit mode every frame with a high stop bit is delivered, regardless of mpEnable, and the comparator does nothing.
- R8: A frame whose stop bit samples low sets frameErr. It raises no interrupt, loads no holding register and causes no comparator action.
- R9: A low pulse on the line that has ended before mid-bit of the start bit produces no frame, and the receiver then decodes the next frame correctly.
- R10: rxIrq stays 1 until a one-cycle irqClear pulse. The same pulse also clears frameErr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rxLine | input | 1 | Serial receive line, idle high |
| baudTick | input | 1 | Oversampling tick, OVERSAMPLE ticks per bit |
| modeNine | input | 1 | 1 = 9-bit frames, 0 = 8-bit frames |
| mpArm | input | 1 | Strobe: set filter enable, clear addressed |
| ownAddr | input | BYTE_W | Own slave address |
| bcastAddr | input | BYTE_W | Broadcast address |
| bcastEn | input | 1 | Enables broadcast address matching |
| irqClear | input | 1 | Write-1-to-clear strobe for rxIrq and frameErr |
| rxData | output | BYTE_W | Last delivered byte |
| rxNinth | output | 1 | Ninth bit of last delivered frame |
| rxIrq | output | 1 | Receive interrupt flag |
| frameErr | output | 1 | Framing error flag |
| mpEnable | output | 1 | Filter enable: data frames dropped while 1 |
| addressed | output | 1 | Set by an address hit, cleared by mpArm |

## Verification
The assertions assume that modeNine, ownAddr, bcastAddr and bcastEn do not change while a frame is in flight. They also assume that baudTick is a single-cycle pulse and that each line level is held for a whole bit period. The bench changes configuration and pulses mpArm or irqClear only while the line idles high between frames. It drives each bit for exactly OVERSAMPLE ticks from a fixed tick divider. It samples the outputs one full idle bit after each stop bit, so the exact cycle of the stop-bit decision does not affect any result.

// File: rtl/mpUartRxPkg.sv
package mpUartRxPkg;
  typedef struct packed {
    logic cntClear;
    logic bitClear;
    logic sampleBit;
    logic loadHold;
  } rxStrobeT;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP
  } rxStateT;
endpackage

// File: rtl/mpUartRxPath.sv
module mpUartRxPath
  import mpUartRxPkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxLine,
  input  logic              baudTick,
  input  logic              modeNine,
  input  logic [BYTE_W-1:0] ownAddr,
  input  logic [BYTE_W-1:0] bcastAddr,
  input  logic              bcastEn,
  input  rxStrobeT          strb,
  output logic              rxBit,
  output logic              midPoint,
  output logic              bitEnd,
  output logic              lastBit,
  output logic              frameNinth,
  output logic              addrHit,
  output logic [BYTE_W-1:0] holdData,
  output logic              holdNinth
);
  localparam int CNT_W = $clog2(OVERSAMPLE);
  localparam int HALF  = OVERSAMPLE / 2;
  localparam int SH_W  = BYTE_W + 1;
  localparam int BIT_W = $clog2(SH_W + 1);

  logic [SYNC_STAGES-1:0] syncReg;
  logic [CNT_W-1:0]       tickCnt;
  logic [BIT_W-1:0]       bitCnt;
  logic [SH_W-1:0]        shiftReg;
  logic [BYTE_W-1:0]      frameByte;

  // line synchronizer, reset to idle level
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncReg <= '1;
    else       syncReg <= {syncReg[SYNC_STAGES-2:0], rxLine};
  end
  assign rxBit = syncReg[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              tickCnt <= '0;
    else if (strb.cntClear) tickCnt <= '0;
    else if (baudTick)      tickCnt <= tickCnt + 1'b1;
  end

  assign midPoint = baudTick && (tickCnt == CNT_W'(HALF - 1));
  assign bitEnd   = baudTick && (tickCnt == CNT_W'(OVERSAMPLE - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               bitCnt <= '0;
    else if (strb.bitClear)  bitCnt <= '0;
    else if (strb.sampleBit) bitCnt <= bitCnt + 1'b1;
  end

  assign lastBit = (bitCnt == (modeNine ? BIT_W'(SH_W - 1) : BIT_W'(BYTE_W - 1)));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               shiftReg <= '0;
    else if (strb.sampleBit) shiftReg <= {rxBit, shiftReg[SH_W-1:1]};
  end

  assign frameByte  = modeNine ? shiftReg[BYTE_W-1:0] : shiftReg[SH_W-1:1];
  assign frameNinth = modeNine & shiftReg[SH_W-1];
  assign addrHit    = (frameByte == ownAddr) || (bcastEn && (frameByte == bcastAddr));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdData  <= '0;
      holdNinth <= 1'b0;
    end else if (strb.loadHold) begin
      holdData  <= frameByte;
      holdNinth <= frameNinth;
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadHold |=> ($stable(holdData) && $stable(holdNinth))); // R4

  AST_NINTH_ZERO_8BIT: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadHold && !modeNine) |=> !holdNinth); // R2
endmodule

// File: rtl/mpUartRxCtrl.sv
module mpUartRxCtrl
  import mpUartRxPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     rxBit,
  input  logic     midPoint,
  input  logic     bitEnd,
  input  logic     lastBit,
  input  logic     frameNinth,
  input  logic     addrHit,
  input  logic     modeNine,
  input  logic     mpArm,
  input  logic     irqClear,
  output rxStrobeT strb,
  output logic     rxIrq,
  output logic     frameErr,
  output logic     mpEnable,
  output logic     addressed
);
  rxStateT state, nextState;
  logic    stopEval, stopOk, filterOn, passFrame, matchEv;

  always_comb begin
    strb      = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        strb.cntClear = 1'b1;
        strb.bitClear = 1'b1;
        if (!rxBit) nextState = ST_START;
      end
      ST_START: begin
        if (midPoint) begin
          strb.cntClear = 1'b1;
          nextState     = rxBit ? ST_IDLE : ST_DATA;
        end
      end
      ST_DATA: begin
        if (bitEnd) begin
          strb.cntClear  = 1'b1;
          strb.sampleBit = 1'b1;
          if (lastBit) nextState = ST_STOP;
        end
      end
      ST_STOP: begin
        if (bitEnd) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
    strb.loadHold = passFrame;
  end

  assign stopEval  = (state == ST_STOP) && bitEnd;
  assign stopOk    = rxBit;
  assign filterOn  = modeNine && mpEnable;
  assign passFrame = stopEval && stopOk && (!filterOn || frameNinth);
  assign matchEv   = stopEval && stopOk && filterOn && frameNinth && addrHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      rxIrq     <= 1'b0;
      frameErr  <= 1'b0;
      mpEnable  <= 1'b0;
      addressed <= 1'b0;
    end else begin
      state <= nextState;
      if (passFrame)     rxIrq <= 1'b1;
      else if (irqClear) rxIrq <= 1'b0;
      if (stopEval && !stopOk) frameErr <= 1'b1;
      else if (irqClear)       frameErr <= 1'b0;
      if (matchEv) begin
        mpEnable  <= 1'b0;
        addressed <= 1'b1;
      end else if (mpArm) begin
        mpEnable  <= 1'b1;
        addressed <= 1'b0;
      end
    end
  end

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (rxIrq && !irqClear) |=> rxIrq); // R10

  AST_FERR_NO_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frameErr) |-> !$rose(rxIrq)); // R8

  AST_ADDR_CLEARS_EN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(addressed) |-> !mpEnable); // R5

  AST_EN_FALL_ON_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    $fell(mpEnable) |-> $past(modeNine && frameNinth && addrHit)); // R5

  AST_ARM_SETS_EN: assert property (@(posedge clk) disable iff (!rstN)
    (mpArm && !(stopEval && frameNinth && addrHit)) |=> (mpEnable && !addressed)); // R6
endmodule

// File: rtl/mpUartRx.sv
module mpUartRx
  import mpUartRxPkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int BYTE_W     = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxLine,
  input  logic              baudTick,
  input  logic              modeNine,
  input  logic              mpArm,
  input  logic [BYTE_W-1:0] ownAddr,
  input  logic [BYTE_W-1:0] bcastAddr,
  input  logic              bcastEn,
  input  logic              irqClear,
  output logic [BYTE_W-1:0] rxData,
  output logic              rxNinth,
  output logic              rxIrq,
  output logic              frameErr,
  output logic              mpEnable,
  output logic              addressed
);
  rxStrobeT strb;
  logic     rxBit, midPoint, bitEnd, lastBit, frameNinth, addrHit;

  mpUartRxPath #(.OVERSAMPLE(OVERSAMPLE), .BYTE_W(BYTE_W), .SYNC_STAGES(2)) uPath (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .baudTick(baudTick),
    .modeNine(modeNine), .ownAddr(ownAddr), .bcastAddr(bcastAddr),
    .bcastEn(bcastEn), .strb(strb), .rxBit(rxBit), .midPoint(midPoint),
    .bitEnd(bitEnd), .lastBit(lastBit), .frameNinth(frameNinth),
    .addrHit(addrHit), .holdData(rxData), .holdNinth(rxNinth)
  );

  mpUartRxCtrl uCtrl (
    .clk(clk), .rstN(rstN), .rxBit(rxBit), .midPoint(midPoint),
    .bitEnd(bitEnd), .lastBit(lastBit), .frameNinth(frameNinth),
    .addrHit(addrHit), .modeNine(modeNine), .mpArm(mpArm),
    .irqClear(irqClear), .strb(strb), .rxIrq(rxIrq), .frameErr(frameErr),
    .mpEnable(mpEnable), .addressed(addressed)
  );
endmodule

// File: tb/mpUartRx_test.sv
`timescale 1ns/1ps
module mpUartRx_test;
  localparam int OS  = 16;
  localparam int BIT = OS * 2;

  typedef struct packed {
    logic       arm;
    logic       nine;
    logic       ninth;
    logic [7:0] data;
    logic       stopGood;
    logic       eIrq;
    logic [7:0] eData;
    logic       eNinth;
    logic       eEn;
    logic       eAddr;
    logic       eFerr;
  } vecT;

  // arm nine ninth data stop | irq data ninth en addr ferr
  localparam vecT VECS [0:10] = '{
    '{1'b1, 1'b1, 1'b0, 8'h33, 1'b1, 1'b0, 8'hA5, 1'b0, 1'b1, 1'b0, 1'b0},
    '{1'b0, 1'b1, 1'b1, 8'h12, 1'b1, 1'b1, 8'h12, 1'b1, 1'b1, 1'b0, 1'b0},
    '{1'b0, 1'b1, 1'b0, 8'h44, 1'b1, 1'b0, 8'h12, 1'b1, 1'b1, 1'b0, 1'b0},
    '{1'b0, 1'b1, 1'b1, 8'h5A, 1'b1, 1'b1, 8'h5A, 1'b1, 1'b0, 1'b1, 1'b0},
    '{1'b0, 1'b1, 1'b0, 8'h77, 1'b1, 1'b1, 8'h77, 1'b0, 1'b0, 1'b1, 1'b0},
    '{1'b0, 1'b1, 1'b1, 8'h12, 1'b1, 1'b1, 8'h12, 1'b1, 1'b0, 1'b1, 1'b0},
    '{1'b1, 1'b1, 1'b1, 8'hFF, 1'b1, 1'b1, 8'hFF, 1'b1, 1'b0, 1'b1, 1'b0},
    '{1'b1, 1'b1, 1'b0, 8'h99, 1'b0, 1'b0, 8'hFF, 1'b1, 1'b1, 1'b0, 1'b1},
    '{1'b0, 1'b0, 1'b0, 8'h3C, 1'b1, 1'b1, 8'h3C, 1'b0, 1'b1, 1'b0, 1'b0},
    '{1'b0, 1'b0, 1'b0, 8'hC3, 1'b0, 1'b0, 8'h3C, 1'b0, 1'b1, 1'b0, 1'b1},
    '{1'b0, 1'b1, 1'b1, 8'h5A, 1'b0, 1'b0, 8'h3C, 1'b0, 1'b1, 1'b0, 1'b1}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxLine = 1'b1;
  logic       tickDiv = 1'b0;
  logic       modeNine = 1'b1;
  logic       mpArm = 1'b0;
  logic [7:0] ownAddr = 8'h5A;
  logic [7:0] bcastAddr = 8'hFF;
  logic       bcastEn = 1'b1;
  logic       irqClear = 1'b0;
  logic [7:0] rxData;
  logic       rxNinth, rxIrq, frameErr, mpEnable, addressed;
  int         checks = 0;
  int         errors = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) tickDiv <= ~tickDiv;

  mpUartRx #(.OVERSAMPLE(OS), .BYTE_W(8)) uut (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .baudTick(tickDiv),
    .modeNine(modeNine), .mpArm(mpArm), .ownAddr(ownAddr),
    .bcastAddr(bcastAddr), .bcastEn(bcastEn), .irqClear(irqClear),
    .rxData(rxData), .rxNinth(rxNinth), .rxIrq(rxIrq), .frameErr(frameErr),
    .mpEnable(mpEnable), .addressed(addressed)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pulse(input bit doArm, input bit doClr);
    @(negedge clk);
    mpArm    = doArm;
    irqClear = doClr;
    @(negedge clk);
    mpArm    = 1'b0;
    irqClear = 1'b0;
  endtask

  task automatic sendFrame(input bit nine, input bit ninth, input logic [7:0] b, input bit stopGood);
    @(negedge clk);
    rxLine = 1'b0;
    repeat (BIT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxLine = b[i];
      repeat (BIT) @(negedge clk);
    end
    if (nine) begin
      rxLine = ninth;
      repeat (BIT) @(negedge clk);
    end
    rxLine = stopGood;
    repeat (BIT) @(negedge clk);
    rxLine = 1'b1;
    repeat (BIT) @(negedge clk);
  endtask

  task automatic summary;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #(100000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rxIrq", {7'd0, rxIrq}, 8'd0);
    chk("R1 frameErr", {7'd0, frameErr}, 8'd0);
    chk("R1 mpEnable", {7'd0, mpEnable}, 8'd0);
    chk("R1 addressed", {7'd0, addressed}, 8'd0);
    chk("R1 rxData", rxData, 8'h00);
    chk("R1 rxNinth", {7'd0, rxNinth}, 8'd0);

    // R9 short glitch is no frame
    @(negedge clk);
    rxLine = 1'b0;
    repeat (6) @(negedge clk);
    rxLine = 1'b1;
    repeat (2 * BIT) @(negedge clk);
    chk("R9 glitch irq", {7'd0, rxIrq}, 8'd0);
    chk("R9 glitch ferr", {7'd0, frameErr}, 8'd0);

    // R3 filter off: data frame delivered; R9 decoder recovered
    sendFrame(1'b1, 1'b0, 8'hA5, 1'b1);
    chk("R3 R9 irq", {7'd0, rxIrq}, 8'd1);
    chk("R2 R9 data", rxData, 8'hA5);
    chk("R2 ninth", {7'd0, rxNinth}, 8'd0);

    // R10 sticky until cleared
    repeat (3 * BIT) @(negedge clk);
    chk("R10 irq sticky", {7'd0, rxIrq}, 8'd1);
    pulse(1'b0, 1'b1);
    chk("R10 irq cleared", {7'd0, rxIrq}, 8'd0);

    // table of vectors: R2 R3 R4 R5 R6 R7 R8 R10
    for (int v = 0; v <= 10; v++) begin
      pulse(1'b0, 1'b1);
      if (VECS[v].arm) pulse(1'b1, 1'b0);
      modeNine = VECS[v].nine;
      sendFrame(VECS[v].nine, VECS[v].ninth, VECS[v].data, VECS[v].stopGood);
      chk($sformatf("vec%0d irq R3 R4 R5 R7 R8", v), {7'd0, rxIrq}, {7'd0, VECS[v].eIrq});
      chk($sformatf("vec%0d data R2 R4 R8", v), rxData, VECS[v].eData);
      chk($sformatf("vec%0d ninth R2", v), {7'd0, rxNinth}, {7'd0, VECS[v].eNinth});
      chk($sformatf("vec%0d mpEnable R5 R6", v), {7'd0, mpEnable}, {7'd0, VECS[v].eEn});
      chk($sformatf("vec%0d addressed R5 R6", v), {7'd0, addressed}, {7'd0, VECS[v].eAddr});
      chk($sformatf("vec%0d frameErr R8 R10", v), {7'd0, frameErr}, {7'd0, VECS[v].eFerr});
    end

    // R10 clear also drops frameErr
    pulse(1'b0, 1'b1);
    chk("R10 ferr cleared", {7'd0, frameErr}, 8'd0);

    // R5 broadcast disabled: no match on broadcast address
    bcastEn  = 1'b0;
    modeNine = 1'b1;
    pulse(1'b1, 1'b0);
    sendFrame(1'b1, 1'b1, 8'hFF, 1'b1);
    chk("R5 nobcast irq", {7'd0, rxIrq}, 8'd1);
    chk("R5 nobcast en", {7'd0, mpEnable}, 8'd1);
    chk("R5 nobcast addr", {7'd0, addressed}, 8'd0);

    summary();
    $finish;
  end
endmodule